// File: doc/BRIEF.md
# PCM Codec Frame Sequencer

This block schedules the conversion work of a companding PCM codec whose decode and encode share one successive-approximation capacitor array. A frame lasts 256 clock cycles, which is 125 µs at 2.048 MHz. Each frame has three parts. First the array is loaded with the PCM word received at the frame strobe, and the held analog output is told to update. Next the analog input is sampled. Last, an 8-bit result is resolved one bit per fixed-length slot against an external comparator. The result has a sign in bit 7, a chord in bits 6:4 and a step in bits 3:0.

The finished result is converted to one of three serial code conventions and held for the next frame's transmit slot. The same conversion is undone on the received word before it is decoded. The sign of each new result is presented as a feedback bit for the offset-cancelling integrator. A digital-loopback input keeps the array at zero during decode and throws away the encoded result. A powerdown input stops the schedule and parks the transmit word at a zero-magnitude code.

Top module: `pcm_conv_seq`

## Requirements
- R1: While reset is asserted and until the first frame strobe, dac_code is 0, the phase outputs (dac_load, hold_strobe, smp_en, sar_busy) are low, tx_word is 8'h00 and sign_fb is 0.
- R2: A frame strobe sampled at a rising edge makes the next cycle frame cycle 0. Cycles 0-50 are decode (dac_load high), cycles 51-87 are sampling (smp_en high) and cycles 88-255 are conversion (sar_busy high). hold_strobe is high in cycle 50 only. After cycle 255 the frame restarts at cycle 0 without a new strobe, and a strobe in any cycle restarts the frame at once.
- R3: During decode, dac_code equals rx_word as captured at the frame strobe, with the fmt_sel conversion of R6 undone.
- R4: Conversion resolves bit 7 (sign), then bits 6:4 (chord), then bits 3:0 (step). Each bit has a slot of 21 cycles. During the slot for bit k, dac_code holds the bits already decided above k, a 1 at k and zeros below. On the last cycle of the slot, cmp_in=1 keeps bit k and cmp_in=0 clears it.
- R5: tx_word changes only at the edge that ends frame cycle 255, or while powerdown is applied. At that edge it loads the converted result.
- R6: fmt_sel selects the code convention: 2'b00 and 2'b11 pass the word unchanged; 2'b01 inverts bits 6:0 and keeps the sign; 2'b10 inverts bits 0, 2, 4 and 6.
- R7: sign_fb takes bit 7 of the new result at the same edge as tx_word.
- R8: With dig_loopback high, dac_code is 0 during decode, and tx_word and sign_fb keep their values through the end of conversion.
- R9: powerdown stops the schedule. From the next cycle all phase outputs are low, dac_code is 0 and tx_word is the R6 conversion of 8'h00. After powerdown is released, nothing runs until a new frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz codec clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame strobe |
| powerdown | input | 1 | Halts the sequencer |
| dig_loopback | input | 1 | Digital loopback: decoder input zeroed, encode discarded |
| fmt_sel | input | 2 | Code convention select |
| rx_word | input | 8 | Received PCM word, captured at frame_start |
| cmp_in | input | 1 | Comparator decision for the current trial |
| dac_code | output | 8 | Sign-magnitude code driven onto the shared array |
| dac_load | output | 1 | Decode phase active |
| hold_strobe | output | 1 | Held analog output updates (last decode cycle) |
| smp_en | output | 1 | Analog input sampling phase |
| sar_busy | output | 1 | Approximation phase active |
| tx_word | output | 8 | Formatted transmit holding register |
| sign_fb | output | 1 | Sign of latest result, to offset integrator |

## Verification
The hardest situations to reach from the ports are the ones where the schedule is cut off: a frame strobe that arrives in the middle of conversion, and powerdown applied partway through a frame. In both, a half-resolved result must never reach tx_word. The bench drives a comparator model that keeps a trial bit whenever the trial code does not exceed a chosen target, so a correct sequencer converges on exactly that target. It then restarts one frame at cycle 100 and powers another down at cycle 120, and checks that tx_word still holds the previous result and that the restarted frame decodes the newly captured word.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;
  localparam int PCM_W = 8;

  typedef enum logic [1:0] {
    FMT_PLAIN   = 2'b00,
    FMT_INV_MAG = 2'b01,
    FMT_ALT     = 2'b10,
    FMT_PLAIN_B = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_DEC  = 2'b01,
    PH_SMP  = 2'b10,
    PH_CONV = 2'b11
  } phase_e;
endpackage

// File: rtl/pcm_code_fmt.sv
module pcm_code_fmt
  import pcm_seq_pkg::*;
#(
  parameter int W = PCM_W
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   sel,
  output logic [W-1:0] dout
);
  logic [W-1:0] flip;

  // Conversion is an XOR mask, so the same logic maps both ways.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_sign
      assign flip[i] = 1'b0;
    end else if ((i % 2) == 0) begin : g_even
      assign flip[i] = (sel == FMT_INV_MAG) || (sel == FMT_ALT);
    end else begin : g_odd
      assign flip[i] = (sel == FMT_INV_MAG);
    end
    assign dout[i] = din[i] ^ flip[i];
  end
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_seq_pkg::*;
#(
  parameter int FRAME_CYCLES = 256,
  parameter int DEC_CYCLES   = 51,
  parameter int SMP_CYCLES   = 37,
  parameter int BIT_CYCLES   = 21,
  parameter int NBITS        = PCM_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic                      powerdown,
  output phase_e                    phase,
  output logic [$clog2(NBITS)-1:0]  bit_idx,
  output logic                      bit_end,
  output logic                      dec_end,
  output logic                      conv_done
);
  localparam int CNT_W  = $clog2(FRAME_CYCLES);
  localparam int SLOT_W = $clog2(BIT_CYCLES);
  localparam int BIDX_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0]  LAST_C    = CNT_W'(FRAME_CYCLES - 1);
  localparam logic [CNT_W-1:0]  DEC_END_C = CNT_W'(DEC_CYCLES - 1);
  localparam logic [CNT_W-1:0]  SMP_LIM_C = CNT_W'(DEC_CYCLES + SMP_CYCLES);
  localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(BIT_CYCLES - 1);
  localparam logic [BIDX_W-1:0] TOP_BIT   = BIDX_W'(NBITS - 1);

  logic              armed_q, armed_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [BIDX_W-1:0] bidx_q, bidx_n;
  logic              in_conv;

  always_comb begin
    if (!armed_q)                     phase = PH_IDLE;
    else if (cnt_q <= DEC_END_C)      phase = PH_DEC;
    else if (cnt_q < SMP_LIM_C)       phase = PH_SMP;
    else                              phase = PH_CONV;
  end

  assign in_conv   = (phase == PH_CONV);
  assign bit_idx   = bidx_q;
  assign bit_end   = in_conv && (slot_q == SLOT_END);
  assign dec_end   = armed_q && (cnt_q == DEC_END_C);
  assign conv_done = bit_end && (bidx_q == '0);

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    slot_n  = slot_q;
    bidx_n  = bidx_q;
    if (powerdown) begin
      armed_n = 1'b0;
      cnt_n   = '0;
      slot_n  = '0;
      bidx_n  = TOP_BIT;
    end else if (frame_start) begin
      armed_n = 1'b1;
      cnt_n   = '0;
      slot_n  = '0;
      bidx_n  = TOP_BIT;
    end else if (armed_q) begin
      cnt_n = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
      if (in_conv) begin
        if (slot_q == SLOT_END) begin
          slot_n = '0;
          bidx_n = bidx_q - 1'b1;
        end else begin
          slot_n = slot_q + 1'b1;
        end
      end else begin
        slot_n = '0;
        bidx_n = TOP_BIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      slot_q  <= '0;
      bidx_q  <= TOP_BIT;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      slot_q  <= slot_n;
      bidx_q  <= bidx_n;
    end
  end

  assert_frame_wrap_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !powerdown && !frame_start && cnt_q == LAST_C) |=> (armed_q && cnt_q == '0));

  assert_bit_order_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && bidx_q != '0 && !powerdown && !frame_start)
      |=> (bidx_q == $past(bidx_q) - 1'b1 && phase == PH_CONV));

  assert_halt_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    powerdown |=> (phase == PH_IDLE));
endmodule

// File: rtl/pcm_sar_core.sv
module pcm_sar_core
  import pcm_seq_pkg::*;
#(
  parameter int NBITS = PCM_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      conv,
  input  logic                      bit_end,
  input  logic [$clog2(NBITS)-1:0]  bit_idx,
  input  logic                      cmp_in,
  output logic [NBITS-1:0]          result,
  output logic [NBITS-1:0]          result_nxt,
  output logic [NBITS-1:0]          trial
);
  logic [NBITS-1:0] res_q;
  logic [NBITS-1:0] probe;

  for (genvar i = 0; i < NBITS; i++) begin : g_probe
    assign probe[i] = conv && (bit_idx == i);
  end

  always_comb begin
    result_nxt = res_q;
    if (clear) begin
      result_nxt = '0;
    end else if (conv && bit_end) begin
      result_nxt[bit_idx] = cmp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= result_nxt;
  end

  assign result = res_q;
  assign trial  = res_q | probe;

  assert_slot_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (conv && !bit_end && !clear) |=> (res_q == $past(res_q)));

  assert_decide_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (conv && bit_end && !clear) |=> (res_q[$past(bit_idx)] == $past(cmp_in)));
endmodule

// File: rtl/pcm_conv_seq.sv
module pcm_conv_seq
  import pcm_seq_pkg::*;
#(
  parameter int FRAME_CYCLES = 256,
  parameter int DEC_CYCLES   = 51,
  parameter int SMP_CYCLES   = 37,
  parameter int BIT_CYCLES   = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       powerdown,
  input  logic       dig_loopback,
  input  logic [1:0] fmt_sel,
  input  logic [7:0] rx_word,
  input  logic       cmp_in,
  output logic [7:0] dac_code,
  output logic       dac_load,
  output logic       hold_strobe,
  output logic       smp_en,
  output logic       sar_busy,
  output logic [7:0] tx_word,
  output logic       sign_fb
);
  localparam int W      = PCM_W;
  localparam int BIDX_W = $clog2(W);

  phase_e            phase;
  logic [BIDX_W-1:0] bit_idx;
  logic              bit_end, dec_end, conv_done;
  logic [W-1:0]      rx_q, rx_n, rx_plain;
  logic [W-1:0]      sar_res, sar_res_nxt, sar_trial;
  logic [W-1:0]      res_fmt, zero_fmt;
  logic [W-1:0]      tx_q, tx_n;
  logic              sf_q, sf_n;

  pcm_frame_timer #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .DEC_CYCLES  (DEC_CYCLES),
    .SMP_CYCLES  (SMP_CYCLES),
    .BIT_CYCLES  (BIT_CYCLES),
    .NBITS       (W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .powerdown  (powerdown),
    .phase      (phase),
    .bit_idx    (bit_idx),
    .bit_end    (bit_end),
    .dec_end    (dec_end),
    .conv_done  (conv_done)
  );

  pcm_sar_core #(.NBITS(W)) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (phase == PH_SMP),
    .conv      (phase == PH_CONV),
    .bit_end   (bit_end),
    .bit_idx   (bit_idx),
    .cmp_in    (cmp_in),
    .result    (sar_res),
    .result_nxt(sar_res_nxt),
    .trial     (sar_trial)
  );

  pcm_code_fmt #(.W(W)) u_rx_fmt   (.din(rx_q),        .sel(fmt_sel), .dout(rx_plain));
  pcm_code_fmt #(.W(W)) u_tx_fmt   (.din(sar_res_nxt), .sel(fmt_sel), .dout(res_fmt));
  pcm_code_fmt #(.W(W)) u_zero_fmt (.din('0),          .sel(fmt_sel), .dout(zero_fmt));

  // Received word capture at the frame strobe.
  always_comb begin
    rx_n = rx_q;
    if (frame_start && !powerdown) rx_n = rx_word;
  end

  // Transmit holding register and sign feedback.
  always_comb begin
    tx_n = tx_q;
    sf_n = sf_q;
    if (powerdown) begin
      tx_n = zero_fmt;
    end else if (conv_done && !dig_loopback) begin
      tx_n = res_fmt;
      sf_n = sar_res_nxt[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      tx_q <= '0;
      sf_q <= 1'b0;
    end else begin
      rx_q <= rx_n;
      tx_q <= tx_n;
      sf_q <= sf_n;
    end
  end

  always_comb begin
    case (phase)
      PH_DEC:  dac_code = dig_loopback ? '0 : rx_plain;
      PH_CONV: dac_code = sar_trial;
      default: dac_code = '0;
    endcase
  end

  assign dac_load    = (phase == PH_DEC);
  assign smp_en      = (phase == PH_SMP);
  assign sar_busy    = (phase == PH_CONV);
  assign hold_strobe = dec_end;
  assign tx_word     = tx_q;
  assign sign_fb     = sf_q;

  assert_pd_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    powerdown |=> (!dac_load && !smp_en && !sar_busy && !hold_strobe));

  assert_tx_stable_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !powerdown) |=> $stable(tx_word));

  assert_lb_keep_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (dig_loopback && !powerdown) |=> ($stable(tx_word) && $stable(sign_fb)));

  assert_sign_fb_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !dig_loopback && !powerdown) |=> (sign_fb == $past(sar_res[W-1])));

  assert_phase_onehot_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dac_load, smp_en, sar_busy}));
endmodule

// File: tb/sim_pcm_conv_seq.sv
module sim_pcm_conv_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start, powerdown, dig_loopback;
  logic [1:0] fmt_sel;
  logic [7:0] rx_word;
  logic [7:0] tgt;
  logic       cmp_in;
  logic [7:0] dac_code, tx_word;
  logic       dac_load, hold_strobe, smp_en, sar_busy, sign_fb;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Comparator model: keep the trial bit when trial <= target.
  assign cmp_in = (dac_code <= tgt);

  pcm_conv_seq u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .powerdown(powerdown),
    .dig_loopback(dig_loopback), .fmt_sel(fmt_sel), .rx_word(rx_word), .cmp_in(cmp_in),
    .dac_code(dac_code), .dac_load(dac_load), .hold_strobe(hold_strobe), .smp_en(smp_en),
    .sar_busy(sar_busy), .tx_word(tx_word), .sign_fb(sign_fb)
  );

  function automatic logic [7:0] fmtf(input logic [7:0] x, input logic [1:0] f);
    case (f)
      2'b01:   return {x[7], ~x[6:0]};
      2'b10:   return x ^ 8'h55;
      default: return x;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Drive a strobe; returns at the negedge inside frame cycle 0.
  task automatic pulse_start(input logic [7:0] rx);
    rx_word     = rx;
    frame_start = 1'b1;
    next_cycle();
    frame_start = 1'b0;
    rx_word     = 8'hXX ^ 8'hXX;
  endtask

  // Check frame cycles c0..c1; sample at negedge, ends at cycle c1+1.
  task automatic run_cycles(input int c0, input int c1, input logic [7:0] rx,
                            input logic lb, input logic [7:0] prev_tx);
    for (int c = c0; c <= c1; c++) begin
      logic [7:0] exp_dac;
      bit dec, smp, conv;
      dec  = (c < 51);
      smp  = (c >= 51) && (c < 88);
      conv = (c >= 88);
      if (dec) exp_dac = lb ? 8'h00 : fmtf(rx, fmt_sel);
      else if (conv) begin
        int j;
        int hi;
        j  = 7 - (c - 88) / 21;
        hi = int'(tgt) & ~((1 << (j + 1)) - 1);
        exp_dac = 8'(hi | (1 << j));
      end else exp_dac = 8'h00;
      if (dec) check(dac_code == exp_dac, lb ? "R8" : "R3", dac_code, exp_dac);
      else if (conv) check(dac_code == exp_dac, "R4", dac_code, exp_dac);
      check({dac_load, smp_en, sar_busy, hold_strobe} == {dec, smp, conv, c == 50},
            "R2", {dac_load, smp_en, sar_busy, hold_strobe}, {dec, smp, conv, c == 50});
      check(tx_word == prev_tx, "R5", tx_word, prev_tx);
      next_cycle();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; frame_start = 1'b0; powerdown = 1'b0; dig_loopback = 1'b0;
    fmt_sel = 2'b00; rx_word = 8'h00; tgt = 8'h00;
    repeat (3) @(negedge clk);
    check({dac_code, dac_load, hold_strobe, smp_en, sar_busy, tx_word, sign_fb} == '0,
          "R1", dac_code, 0);
    rst_n = 1'b1;
    repeat (20) next_cycle();
    check({dac_code, dac_load, smp_en, sar_busy, tx_word} == '0, "R1", tx_word, 0);
  endtask

  task automatic t_frame(input logic [1:0] f, input logic [7:0] rx,
                         input logic [7:0] t, input logic lb);
    logic [7:0] prev_tx;
    logic       prev_sf;
    fmt_sel = f; tgt = t; dig_loopback = lb;
    prev_tx = tx_word; prev_sf = sign_fb;
    pulse_start(rx);
    run_cycles(0, 255, rx, lb, prev_tx);
    if (lb) begin
      check(tx_word == prev_tx, "R8", tx_word, prev_tx);
      check(sign_fb == prev_sf, "R8", sign_fb, prev_sf);
    end else begin
      check(tx_word == fmtf(t, f), "R6", tx_word, fmtf(t, f));
      check(sign_fb == t[7], "R7", sign_fb, t[7]);
    end
    check(dac_load == 1'b1, "R2", dac_load, 1);
    dig_loopback = 1'b0;
  endtask

  task automatic t_realign();
    logic [7:0] prev_tx;
    fmt_sel = 2'b00; tgt = 8'h3C;
    prev_tx = tx_word;
    pulse_start(8'h11);
    run_cycles(0, 100, 8'h11, 1'b0, prev_tx);
    pulse_start(8'h9A);
    check(dac_load == 1'b1 && dac_code == 8'h9A, "R2", dac_code, 8'h9A);
    check(tx_word == prev_tx, "R5", tx_word, prev_tx);
    run_cycles(0, 255, 8'h9A, 1'b0, prev_tx);
    check(tx_word == 8'h3C, "R5", tx_word, 8'h3C);
  endtask

  task automatic t_powerdown();
    fmt_sel = 2'b10; tgt = 8'hE1;
    pulse_start(8'h42);
    run_cycles(0, 120, 8'h42, 1'b0, tx_word);
    powerdown = 1'b1;
    next_cycle();
    check({dac_load, smp_en, sar_busy} == 3'b000 && dac_code == 8'h00, "R9", dac_code, 0);
    check(tx_word == fmtf(8'h00, 2'b10), "R9", tx_word, fmtf(8'h00, 2'b10));
    fmt_sel = 2'b01;
    next_cycle();
    check(tx_word == fmtf(8'h00, 2'b01), "R9", tx_word, fmtf(8'h00, 2'b01));
    powerdown = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (dac_load || smp_en || sar_busy || hold_strobe) begin
        check(1'b0, "R9", 1, 0);
        break;
      end
      next_cycle();
    end
    check(tx_word == 8'h7F, "R9", tx_word, 8'h7F);
  endtask

  initial begin
    t_reset();
    t_frame(2'b00, 8'hC3, 8'hA7, 1'b0);
    t_frame(2'b01, 8'h5A, 8'h35, 1'b0);
    t_frame(2'b10, 8'h0F, 8'hFF, 1'b0);
    t_frame(2'b11, 8'h80, 8'h00, 1'b0);
    t_frame(2'b10, 8'h80, 8'h80, 1'b0);
    t_frame(2'b01, 8'hE4, 8'h9B, 1'b1);
    t_realign();
    t_powerdown();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule